// File: doc/BRIEF.md
# SMBus Bus-Free Detector and Start Scheduler

This block tracks whether a shared two-wire bus is occupied and decides when a master START that is waiting may be released to the protocol engine. It watches the synchronized clock and data line levels and the start and stop event strobes that a line decoder has already extracted. A START event marks the bus occupied. The bus becomes available again when a STOP event is seen. It also becomes available when the idle timer is enabled and both lines stay high for a programmed length of time, even though no STOP was seen.

Once the bus is available, a settling delay must elapse before the block raises its grant. The block issues a single-cycle grant pulse while a start request is held. Both the idle timeout and the settling delay are derived from an 8-bit rate value: the timeout is (rate+1)·IDLE_MULT cycles and the delay is (rate+1)·DLY_MULT cycles. The defaults are IDLE_MULT = 32 and DLY_MULT = 2. A request made while the bus is occupied waits, and it is released on its own once the bus frees and the delay has passed. Driving the START waveform itself is left to the protocol engine.

Top module: `smb_free_sched`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `bus_busy` is 0 and `start_grant` is 0.
- R2: A cycle with `start_det` high makes `bus_busy` 1 from the next cycle on. This takes priority over a `stop_det` in the same cycle.
- R3: A cycle with `stop_det` high (and `start_det` low) makes `bus_busy` 0 from the next cycle on.
- R4: With `free_en` at 1, `bus_busy` stays 1 for the first (rate+1)·IDLE_MULT cycles counted after the last START or low level. It falls one cycle later if `scl_in` and `sda_in` were high in every one of those cycles.
- R5: A single cycle with `scl_in` or `sda_in` at 0, or with `start_det` at 1, restarts the idle count from zero.
- R6: With `free_en` at 0, no length of idle-high time frees the bus; only a STOP does.
- R7: With `start_req` held at 1, `start_grant` first rises D+1 cycles after the cycle in which `bus_busy` fell, where D = (rate+1)·DLY_MULT. This applies whether the bus was freed by a STOP or by the idle timeout.
- R8: `start_grant` is high for exactly one cycle. It is raised only if `start_req` was 1 on the previous edge. It is not repeated while `start_req` stays 1 and the bus stays free. After `start_req` is dropped and raised again on a free, settled bus, the grant appears on the next cycle.
- R9: A START seen while the delay is running withdraws the pending grant: no grant is issued until the bus has freed again.
- R10: With the default parameters and rate 255, the idle timeout is 8192 cycles. At 100 MHz that is more than 50 µs of bus-high time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Synchronized clock line level |
| sda_in | input | 1 | Synchronized data line level |
| start_det | input | 1 | One-cycle strobe: START seen on the bus |
| stop_det | input | 1 | One-cycle strobe: STOP seen on the bus |
| free_en | input | 1 | Enables freeing the bus by idle timeout |
| rate_val | input | 8 | Rate value; sets the idle timeout and the start delay |
| start_req | input | 1 | A master START is pending |
| bus_busy | output | 1 | Bus is occupied |
| start_grant | output | 1 | One-cycle permission to issue the START |

## Verification
A wrong busy flag shows on `bus_busy` one cycle after the START, STOP or timeout that should have changed it. A wrong idle count shows as a free edge that comes early, comes late, or never comes, measured in exact cycles from the last low level. A wrong settling counter or grant latch shows on `start_grant`: the pulse lands at the wrong cycle, lasts more than one cycle, repeats, or survives a START. Each case can be seen within the one timeout or delay window in which it occurs.

// File: rtl/smb_free_pkg.sv
package smb_free_pkg;
  // bits needed to hold (2**rate_w) * mult
  function automatic int unsigned span_width(input int unsigned rate_w,
                                             input int unsigned mult);
    return $clog2(((2 ** rate_w) * mult) + 1);
  endfunction
endpackage

// File: rtl/smb_idle_timer.sv
module smb_idle_timer #(
  parameter int unsigned RATE_W    = 8,
  parameter int unsigned IDLE_MULT = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              scl,
  input  logic              sda,
  input  logic              start_det,
  input  logic [RATE_W-1:0] rate,
  output logic              timeout
);
  localparam int unsigned CW = smb_free_pkg::span_width(RATE_W, IDLE_MULT);

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;
  logic          quiet;

  assign limit = (CW'(rate) + CW'(1)) * CW'(IDLE_MULT);
  assign quiet = en && scl && sda && !start_det;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      timeout <= 1'b0;
    end else begin
      timeout <= 1'b0;
      if (!quiet) begin
        cnt <= '0;
      end else if (cnt < limit) begin
        cnt <= cnt + CW'(1);
        if (cnt == limit - CW'(1)) timeout <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/smb_busy_track.sv
module smb_busy_track (
  input  logic clk,
  input  logic rst,
  input  logic start_det,
  input  logic stop_det,
  input  logic timeout,
  output logic busy
);
  always_ff @(posedge clk) begin
    if (rst)                       busy <= 1'b0;
    else if (start_det)            busy <= 1'b1;
    else if (stop_det || timeout)  busy <= 1'b0;
  end
endmodule

// File: rtl/smb_start_delay.sv
module smb_start_delay #(
  parameter int unsigned RATE_W   = 8,
  parameter int unsigned DLY_MULT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy,
  input  logic              start_det,
  input  logic              start_req,
  input  logic [RATE_W-1:0] rate,
  output logic              grant
);
  localparam int unsigned DW = smb_free_pkg::span_width(RATE_W, DLY_MULT);

  logic [DW-1:0] dcnt;
  logic [DW-1:0] dlen;
  logic          settled;
  logic          granted;

  assign dlen    = (DW'(rate) + DW'(1)) * DW'(DLY_MULT);
  assign settled = (dcnt >= dlen);

  always_ff @(posedge clk) begin
    if (rst) begin
      dcnt    <= '0;
      granted <= 1'b0;
      grant   <= 1'b0;
    end else begin
      grant <= 1'b0;
      if (busy)          dcnt <= '0;
      else if (!settled) dcnt <= dcnt + DW'(1);

      if (busy || !start_req) begin
        granted <= 1'b0;
      end else if (settled && !granted && !start_det) begin
        grant   <= 1'b1;
        granted <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/smb_free_sched.sv
module smb_free_sched #(
  parameter int unsigned RATE_W    = 8,
  parameter int unsigned IDLE_MULT = 32,
  parameter int unsigned DLY_MULT  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              free_en,
  input  logic [RATE_W-1:0] rate_val,
  input  logic              start_req,
  output logic              bus_busy,
  output logic              start_grant
);
  logic idle_to;

  smb_idle_timer #(.RATE_W(RATE_W), .IDLE_MULT(IDLE_MULT)) u_idle (
    .clk(clk), .rst(rst), .en(free_en), .scl(scl_in), .sda(sda_in),
    .start_det(start_det), .rate(rate_val), .timeout(idle_to)
  );

  smb_busy_track u_busy (
    .clk(clk), .rst(rst), .start_det(start_det), .stop_det(stop_det),
    .timeout(idle_to), .busy(bus_busy)
  );

  smb_start_delay #(.RATE_W(RATE_W), .DLY_MULT(DLY_MULT)) u_dly (
    .clk(clk), .rst(rst), .busy(bus_busy), .start_det(start_det),
    .start_req(start_req), .rate(rate_val), .grant(start_grant)
  );
endmodule

// File: rtl/smb_free_sched_chk.sv
module smb_free_sched_chk #(
  parameter int unsigned RATE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              start_det,
  input logic              stop_det,
  input logic              free_en,
  input logic              start_req,
  input logic [RATE_W-1:0] rate_val,
  input logic              bus_busy,
  input logic              start_grant
);
  // R2
  p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
    start_det |=> bus_busy);
  // R3
  p_stop_free_r3: assert property (@(posedge clk) disable iff (rst)
    (stop_det && !start_det) |=> !bus_busy);
  // R6
  p_hold_no_timer_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_busy && !free_en && $past(!free_en) && !stop_det) |=> bus_busy);
  // R8
  p_grant_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    start_grant |=> !start_grant);
  // R8
  p_grant_req_r8: assert property (@(posedge clk) disable iff (rst)
    start_grant |-> $past(start_req));
  // R9
  p_grant_free_r9: assert property (@(posedge clk) disable iff (rst)
    start_grant |-> !bus_busy);
  // R9
  p_start_kills_r9: assert property (@(posedge clk) disable iff (rst)
    start_det |=> !start_grant);
endmodule

bind smb_free_sched smb_free_sched_chk #(.RATE_W(RATE_W)) u_chk (
  .clk(clk), .rst(rst), .start_det(start_det), .stop_det(stop_det),
  .free_en(free_en), .start_req(start_req), .rate_val(rate_val),
  .bus_busy(bus_busy), .start_grant(start_grant)
);

// File: tb/sim_smb_free_sched.sv
`timescale 1ns/1ps
module sim_smb_free_sched;
  localparam int RATE = 3;
  localparam int T    = (RATE + 1) * 32;
  localparam int D    = (RATE + 1) * 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_in = 1'b1, sda_in = 1'b1;
  logic       start_det = 1'b0, stop_det = 1'b0;
  logic       free_en = 1'b0;
  logic [7:0] rate_val = 8'(RATE);
  logic       start_req = 1'b0;
  logic       bus_busy, start_grant;

  int n_run  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  smb_free_sched u0 (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .start_det(start_det), .stop_det(stop_det), .free_en(free_en),
    .rate_val(rate_val), .start_req(start_req),
    .bus_busy(bus_busy), .start_grant(start_grant)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    start_det = 1'b1; @(negedge clk); start_det = 1'b0;
  endtask

  task automatic pulse_stop();
    stop_det = 1'b1; @(negedge clk); stop_det = 1'b0;
  endtask

  // counts negedges after the current one until grant (cap lim)
  task automatic wait_grant(input int lim, output int n);
    n = 0;
    while (!start_grant && n < lim) begin @(negedge clk); n++; end
  endtask

  task automatic t_reset();
    chk(bus_busy == 1'b0 && start_grant == 1'b0, "R1", {bus_busy, start_grant}, 0);
    @(negedge clk); rst = 1'b0;
    chk(bus_busy == 1'b0 && start_grant == 1'b0, "R1", {bus_busy, start_grant}, 0);
    @(negedge clk);
  endtask

  task automatic t_start_stop();
    pulse_start();
    chk(bus_busy == 1'b1, "R2", bus_busy, 1);
    start_det = 1'b1; stop_det = 1'b1; @(negedge clk);
    start_det = 1'b0; stop_det = 1'b0;
    chk(bus_busy == 1'b1, "R2 priority", bus_busy, 1);
    pulse_stop();
    chk(bus_busy == 1'b0, "R3", bus_busy, 0);
    repeat (D + 4) @(negedge clk);
    chk(start_grant == 1'b0, "R8 no req", start_grant, 0);
  endtask

  task automatic t_stop_grant();
    int n;
    pulse_start();
    start_req = 1'b1;
    repeat (5) @(negedge clk);
    chk(start_grant == 1'b0, "R7 busy hold", start_grant, 0);
    pulse_stop();
    wait_grant(3 * D, n);
    chk(n == D + 1, "R7 stop delay", n, D + 1);
    @(negedge clk);
    chk(start_grant == 1'b0, "R8 single", start_grant, 0);
    n = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); if (start_grant) n++;
    end
    chk(n == 0, "R8 no repeat", n, 0);
    start_req = 1'b0; @(negedge clk);
    start_req = 1'b1; @(negedge clk);
    chk(start_grant == 1'b1, "R8 rerequest", start_grant, 1);
    start_req = 1'b0; @(negedge clk);
  endtask

  task automatic t_withdraw();
    int n;
    pulse_start();
    start_req = 1'b1;
    pulse_stop();
    repeat (3) @(negedge clk);
    pulse_start();
    n = 0;
    for (int i = 0; i < D + 6; i++) begin
      if (start_grant) n++;
      @(negedge clk);
    end
    chk(n == 0 && bus_busy == 1'b1, "R9 withdrawn", n, 0);
    pulse_stop();
    wait_grant(3 * D, n);
    chk(n == D + 1, "R9 regrant", n, D + 1);
    start_req = 1'b0; @(negedge clk);
  endtask

  task automatic t_idle();
    int n;
    free_en = 1'b1;
    pulse_start();
    repeat (T) @(negedge clk);
    chk(bus_busy == 1'b1, "R4 before", bus_busy, 1);
    @(negedge clk);
    chk(bus_busy == 1'b0, "R4 after", bus_busy, 0);
    start_req = 1'b1;
    wait_grant(3 * D, n);
    chk(n == D + 1, "R7 idle delay", n, D + 1);
    start_req = 1'b0;
    pulse_start();
    repeat (100) @(negedge clk);
    sda_in = 1'b0; @(negedge clk); sda_in = 1'b1;
    repeat (T) @(negedge clk);
    chk(bus_busy == 1'b1, "R5 sda restart", bus_busy, 1);
    @(negedge clk);
    chk(bus_busy == 1'b0, "R5 sda free", bus_busy, 0);
    pulse_start();
    repeat (60) @(negedge clk);
    scl_in = 1'b0; @(negedge clk); scl_in = 1'b1;
    repeat (T) @(negedge clk);
    chk(bus_busy == 1'b1, "R5 scl restart", bus_busy, 1);
    @(negedge clk);
    chk(bus_busy == 1'b0, "R5 scl free", bus_busy, 0);
  endtask

  task automatic t_no_timer();
    free_en = 1'b0;
    pulse_start();
    repeat (3 * T) @(negedge clk);
    chk(bus_busy == 1'b1, "R6 stays busy", bus_busy, 1);
    pulse_stop();
    chk(bus_busy == 1'b0, "R6 stop frees", bus_busy, 0);
  endtask

  task automatic t_max_rate();
    rate_val = 8'd255;
    free_en  = 1'b1;
    pulse_start();
    repeat (8192) @(negedge clk);
    chk(bus_busy == 1'b1, "R10 before", bus_busy, 1);
    @(negedge clk);
    chk(bus_busy == 1'b0, "R10 after", bus_busy, 0);
    free_en  = 1'b0;
    rate_val = 8'(RATE);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_start_stop();
    t_stop_grant();
    t_withdraw();
    t_idle();
    t_no_timer();
    t_max_rate();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule